// File: doc/BRIEF.md
# Switch Marked-Packet Hop Logger

This block sits next to one switch pipeline and watches two header streams: packets as they arrive at an input, and packets as they leave on an output. Most traffic passes unnoticed. A packet whose monitoring flag is set is followed through the switch. On arrival, its source and destination identifiers, its tag, its input-queue position and the local arrival time are placed in a small in-flight table. When a marked packet with the same tag departs, the table entry is completed. The block adds the output port, the departure time and an out-of-credit condition flag, and then writes a 128-bit record into a local circular log.

Management software empties the log through a ready/valid drain port, one record per handshake, oldest first. The log is bounded. When it is full and nothing is being drained, a new record replaces the oldest one and a sticky overflow flag rises. Timestamps come from a free-running local counter that is allowed to wrap. Records from many switches can later be matched hop by hop using source, destination, tag and time.

Top module: `hop_logger`

## Requirements
- R1: A local time counter loads TIME_START during reset and then advances by one every clock, wrapping modulo 2^32. The arrival time is the counter value in the cycle the arrival is presented. The departure time is the counter value in the cycle the departure is presented.
- R2: An arrival with `arr_valid` and `arr_mark` both high is stored in the lowest-numbered free slot of the SLOTS-entry in-flight table. An arrival with `arr_mark` low leaves no trace.
- R3: A marked arrival that finds every slot occupied is dropped, and no record is ever produced for it.
- R4: A departure with `dep_valid` and `dep_mark` high whose `dep_tag` equals the tag of an occupied slot completes that slot. If several slots match, the lowest-numbered one is used. One record is written at that clock edge, the slot is freed, and the record is visible on the drain port in the next cycle.
- R5: A departure with `dep_mark` low, or whose tag matches no occupied slot, writes nothing and frees nothing.
- R6: Record layout, bit 127 down to 0: zeros [127:117], out-of-credit flag [116], input-queue position [115:110], output port [109:104], source ID [103:92], destination ID [91:80], tag [79:64], arrival time [63:32], departure time [31:0].
- R7: `drain_valid` is high exactly when the log holds at least one record, and `drain_data` is then the oldest record. A cycle with `drain_valid` and `drain_ready` both high removes that one record. Reset empties the log.
- R8: If a record is written while the log already holds DEPTH records and no record is removed in that cycle, the oldest record is discarded and `overflow` goes high, staying high until reset. If a removal happens in the same cycle, nothing is lost.
- R9: In one cycle, a departure only matches slots occupied before that cycle, and an arrival only takes slots free before that cycle. A same-cycle arrival is therefore never matched, and a slot freed in a cycle is not reused in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arr_valid | input | 1 | Arrival header present this cycle |
| arr_mark | input | 1 | Monitoring flag of the arriving packet |
| arr_src | input | 12 | Source ID of the arriving packet |
| arr_dst | input | 12 | Destination ID of the arriving packet |
| arr_tag | input | 16 | Tag of the arriving packet |
| arr_qpos | input | 6 | Input-queue position on arrival |
| dep_valid | input | 1 | Departure header present this cycle |
| dep_mark | input | 1 | Monitoring flag of the departing packet |
| dep_tag | input | 16 | Tag of the departing packet |
| dep_port | input | 6 | Output port (next hop) |
| dep_no_credit | input | 1 | Output had no credit at transmit |
| drain_ready | input | 1 | Drain side accepts a record |
| drain_valid | output | 1 | A record is available |
| drain_data | output | 128 | Oldest record in the log |
| overflow | output | 1 | Sticky: a record was overwritten |

## Verification
The bench builds the logger with DEPTH set to 8, so the overwrite-oldest path and the sticky flag can be reached after a handful of packets. It also exercises a write into a full log in the same cycle as a removal. TIME_START is set sixteen counts below the top of the 32-bit range, so the very first packet has a departure time that has wrapped past its arrival time. SLOTS stays at 4, so a fifth concurrent marked packet, duplicate tags and same-cycle arrival/departure collisions can all be driven directly.

// File: rtl/hop_log_pkg.sv
package hop_log_pkg;
    localparam int DEF_SRC_W  = 12;
    localparam int DEF_DST_W  = 12;
    localparam int DEF_TAG_W  = 16;
    localparam int DEF_PORT_W = 6;
    localparam int DEF_QPOS_W = 6;
    localparam int DEF_TIME_W = 32;
    localparam int DEF_REC_W  = 128;
    localparam int DEF_DEPTH  = 128;
    localparam int DEF_SLOTS  = 4;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/hop_log_clock.sv
module hop_log_clock #(
    parameter int TIME_W = 32,
    parameter logic [TIME_W-1:0] TIME_START = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [TIME_W-1:0] now
);
    typedef struct packed {
        logic [TIME_W-1:0] t;
    } clk_st_t;

    clk_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        st_d.t = st_q.t + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.t <= TIME_START;
        else        st_q   <= st_d;
    end

    assign now = st_q.t;
endmodule

// File: rtl/hop_log_flight.sv
module hop_log_flight #(
    parameter int SRC_W  = 12,
    parameter int DST_W  = 12,
    parameter int TAG_W  = 16,
    parameter int PORT_W = 6,
    parameter int QPOS_W = 6,
    parameter int TIME_W = 32,
    parameter int SLOTS  = 4,
    parameter int REC_W  = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] now,
    input  logic              arr_valid,
    input  logic              arr_mark,
    input  logic [SRC_W-1:0]  arr_src,
    input  logic [DST_W-1:0]  arr_dst,
    input  logic [TAG_W-1:0]  arr_tag,
    input  logic [QPOS_W-1:0] arr_qpos,
    input  logic              dep_valid,
    input  logic              dep_mark,
    input  logic [TAG_W-1:0]  dep_tag,
    input  logic [PORT_W-1:0] dep_port,
    input  logic              dep_no_credit,
    output logic              rec_we,
    output logic [REC_W-1:0]  rec_data
);
    localparam int IDX_W  = hop_log_pkg::idx_width(SLOTS);
    localparam int USED_W = 1 + QPOS_W + PORT_W + SRC_W + DST_W + TAG_W + 2 * TIME_W;
    localparam int PAD_W  = REC_W - USED_W;

    typedef struct packed {
        logic              used;
        logic [TAG_W-1:0]  tag;
        logic [SRC_W-1:0]  src;
        logic [DST_W-1:0]  dst;
        logic [QPOS_W-1:0] qpos;
        logic [TIME_W-1:0] t_arr;
    } slot_t;

    typedef struct packed {
        slot_t [SLOTS-1:0] slot;
    } fl_st_t;

    fl_st_t           st_d, st_q;
    logic             hit_found, free_found, take, put;
    logic [IDX_W-1:0] hit_idx, free_idx;
    slot_t            hs;

    always_comb begin
        st_d       = st_q;
        hit_found  = 1'b0;
        free_found = 1'b0;
        hit_idx    = '0;
        free_idx   = '0;
        // both searches look only at the registered table
        for (int i = 0; i < SLOTS; i++) begin
            if (!hit_found && st_q.slot[i].used && st_q.slot[i].tag == dep_tag) begin
                hit_found = 1'b1;
                hit_idx   = IDX_W'(i);
            end
            if (!free_found && !st_q.slot[i].used) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
        take     = dep_valid && dep_mark && hit_found;
        put      = arr_valid && arr_mark && free_found;
        hs       = st_q.slot[hit_idx];
        rec_data = {{PAD_W{1'b0}}, dep_no_credit, hs.qpos, dep_port,
                    hs.src, hs.dst, hs.tag, hs.t_arr, now};
        if (take) st_d.slot[hit_idx].used = 1'b0;
        if (put) begin
            st_d.slot[free_idx].used  = 1'b1;
            st_d.slot[free_idx].tag   = arr_tag;
            st_d.slot[free_idx].src   = arr_src;
            st_d.slot[free_idx].dst   = arr_dst;
            st_d.slot[free_idx].qpos  = arr_qpos;
            st_d.slot[free_idx].t_arr = now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rec_we = take;
endmodule

// File: rtl/hop_log_ring.sv
module hop_log_ring #(
    parameter int REC_W = 128,
    parameter int DEPTH = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REC_W-1:0] wr_data,
    input  logic             drain_ready,
    output logic             drain_valid,
    output logic [REC_W-1:0] drain_data,
    output logic             overflow
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW:0] wr;
        logic [AW:0] rd;
        logic        ovf;
    } ring_st_t;

    ring_st_t         st_d, st_q;
    logic [REC_W-1:0] mem [DEPTH];
    logic             empty, full, pop, clobber;

    always_comb begin
        st_d    = st_q;
        empty   = (st_q.wr == st_q.rd);
        full    = (st_q.wr[AW-1:0] == st_q.rd[AW-1:0]) && (st_q.wr[AW] != st_q.rd[AW]);
        pop     = drain_ready && !empty;
        clobber = wr_en && full && !pop;
        if (wr_en)         st_d.wr  = st_q.wr + 1'b1;
        if (pop || clobber) st_d.rd = st_q.rd + 1'b1;
        if (clobber)       st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[st_q.wr[AW-1:0]] <= wr_data;
    end

    assign drain_valid = !empty;
    assign drain_data  = mem[st_q.rd[AW-1:0]];
    assign overflow    = st_q.ovf;
endmodule

// File: rtl/hop_logger.sv
module hop_logger #(
    parameter int SRC_W  = hop_log_pkg::DEF_SRC_W,
    parameter int DST_W  = hop_log_pkg::DEF_DST_W,
    parameter int TAG_W  = hop_log_pkg::DEF_TAG_W,
    parameter int PORT_W = hop_log_pkg::DEF_PORT_W,
    parameter int QPOS_W = hop_log_pkg::DEF_QPOS_W,
    parameter int TIME_W = hop_log_pkg::DEF_TIME_W,
    parameter int REC_W  = hop_log_pkg::DEF_REC_W,
    parameter int DEPTH  = hop_log_pkg::DEF_DEPTH,
    parameter int SLOTS  = hop_log_pkg::DEF_SLOTS,
    parameter logic [TIME_W-1:0] TIME_START = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arr_valid,
    input  logic              arr_mark,
    input  logic [SRC_W-1:0]  arr_src,
    input  logic [DST_W-1:0]  arr_dst,
    input  logic [TAG_W-1:0]  arr_tag,
    input  logic [QPOS_W-1:0] arr_qpos,
    input  logic              dep_valid,
    input  logic              dep_mark,
    input  logic [TAG_W-1:0]  dep_tag,
    input  logic [PORT_W-1:0] dep_port,
    input  logic              dep_no_credit,
    input  logic              drain_ready,
    output logic              drain_valid,
    output logic [REC_W-1:0]  drain_data,
    output logic              overflow
);
    logic [TIME_W-1:0] tick;
    logic              log_we;
    logic [REC_W-1:0]  log_rec;

    hop_log_clock #(.TIME_W(TIME_W), .TIME_START(TIME_START)) u_clock (
        .clk(clk), .rst_n(rst_n), .now(tick)
    );

    hop_log_flight #(
        .SRC_W(SRC_W), .DST_W(DST_W), .TAG_W(TAG_W), .PORT_W(PORT_W),
        .QPOS_W(QPOS_W), .TIME_W(TIME_W), .SLOTS(SLOTS), .REC_W(REC_W)
    ) u_flight (
        .clk(clk), .rst_n(rst_n), .now(tick),
        .arr_valid(arr_valid), .arr_mark(arr_mark), .arr_src(arr_src),
        .arr_dst(arr_dst), .arr_tag(arr_tag), .arr_qpos(arr_qpos),
        .dep_valid(dep_valid), .dep_mark(dep_mark), .dep_tag(dep_tag),
        .dep_port(dep_port), .dep_no_credit(dep_no_credit),
        .rec_we(log_we), .rec_data(log_rec)
    );

    hop_log_ring #(.REC_W(REC_W), .DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n), .wr_en(log_we), .wr_data(log_rec),
        .drain_ready(drain_ready), .drain_valid(drain_valid),
        .drain_data(drain_data), .overflow(overflow)
    );
endmodule

// File: rtl/hop_logger_chk.sv
module hop_logger_chk #(
    parameter int TIME_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dep_valid,
    input logic              dep_mark,
    input logic              drain_valid,
    input logic              drain_ready,
    input logic              overflow,
    input logic [TIME_W-1:0] now,
    input logic              log_we
);
    a_r1_tick_advances: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> now == $past(now) + 1'b1);

    a_r4_write_needs_marked_dep: assert property (@(posedge clk) disable iff (!rst_n)
        log_we |-> (dep_valid && dep_mark));

    a_r7_valid_holds_without_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_valid && !drain_ready) |=> drain_valid);

    a_r7_valid_falls_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drain_valid) |-> $past(drain_ready));

    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

bind hop_logger hop_logger_chk #(.TIME_W(TIME_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .dep_valid(dep_valid), .dep_mark(dep_mark),
    .drain_valid(drain_valid), .drain_ready(drain_ready), .overflow(overflow),
    .now(tick), .log_we(log_we)
);

// File: tb/hop_logger_bench.sv
module hop_logger_bench;
    localparam int          DEPTH = 8;
    localparam int          SLOTS = 4;
    localparam logic [31:0] START = 32'hFFFF_FFF0;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        arr_valid, arr_mark, dep_valid, dep_mark, dep_no_credit, drain_ready;
    logic [11:0] arr_src, arr_dst;
    logic [15:0] arr_tag, dep_tag;
    logic [5:0]  arr_qpos, dep_port;
    logic        drain_valid, overflow;
    logic [127:0] drain_data;

    always #4 clk = ~clk;

    hop_logger #(.DEPTH(DEPTH), .SLOTS(SLOTS), .TIME_START(START)) u_hop_logger (
        .clk(clk), .rst_n(rst_n),
        .arr_valid(arr_valid), .arr_mark(arr_mark), .arr_src(arr_src),
        .arr_dst(arr_dst), .arr_tag(arr_tag), .arr_qpos(arr_qpos),
        .dep_valid(dep_valid), .dep_mark(dep_mark), .dep_tag(dep_tag),
        .dep_port(dep_port), .dep_no_credit(dep_no_credit),
        .drain_ready(drain_ready), .drain_valid(drain_valid),
        .drain_data(drain_data), .overflow(overflow)
    );

    int checks = 0;
    int errors = 0;
    string cur = "R7";
    bit done = 0;

    // reference model
    logic [127:0] mq[$];
    logic         movf;
    logic [31:0]  mnow;
    bit           sv[SLOTS];
    logic [15:0]  stag[SLOTS];
    logic [11:0]  ssrc[SLOTS], sdst[SLOTS];
    logic [5:0]   sq[SLOTS];
    logic [31:0]  sarr[SLOTS];

    task automatic check(input string req, input bit ok, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        arr_valid = 0; arr_mark = 0; arr_src = '0; arr_dst = '0; arr_tag = '0; arr_qpos = '0;
        dep_valid = 0; dep_mark = 0; dep_tag = '0; dep_port = '0; dep_no_credit = 0;
        drain_ready = 0;
    endtask

    task automatic model_update();
        int hit = -1;
        int fr = -1;
        bit push = 0;
        logic [127:0] rec = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (hit < 0 && sv[i] && stag[i] == dep_tag) hit = i;
            if (fr < 0 && !sv[i]) fr = i;
        end
        if (dep_valid && dep_mark && hit >= 0) begin
            push = 1;
            rec[116] = dep_no_credit;
            rec[115:110] = sq[hit];
            rec[109:104] = dep_port;
            rec[103:92] = ssrc[hit];
            rec[91:80] = sdst[hit];
            rec[79:64] = stag[hit];
            rec[63:32] = sarr[hit];
            rec[31:0] = mnow;
        end
        if (arr_valid && arr_mark && fr >= 0) begin
            sv[fr] = 1; stag[fr] = arr_tag; ssrc[fr] = arr_src;
            sdst[fr] = arr_dst; sq[fr] = arr_qpos; sarr[fr] = mnow;
        end
        if (push) sv[hit] = 0;
        if (drain_ready && mq.size() > 0) void'(mq.pop_front());
        if (push) begin
            if (mq.size() == DEPTH) begin
                void'(mq.pop_front());
                movf = 1;
            end
            mq.push_back(rec);
        end
        mnow = mnow + 1;
    endtask

    task automatic compare();
        bit ev = (mq.size() > 0);
        check({cur, " drain_valid"}, drain_valid === ev, 128'(drain_valid), 128'(ev));
        if (ev) check({cur, " drain_data"}, drain_data === mq[0], drain_data, mq[0]);
        check({cur, " overflow"}, overflow === movf, 128'(overflow), 128'(movf));
    endtask

    task automatic step();
        model_update();
        @(posedge clk);
        @(negedge clk);
        compare();
        idle();
    endtask

    task automatic arrive(input logic [15:0] tag, input logic [11:0] s, input logic [11:0] d, input logic [5:0] q);
        arr_valid = 1; arr_mark = 1; arr_tag = tag; arr_src = s; arr_dst = d; arr_qpos = q;
    endtask

    task automatic depart(input logic [15:0] tag, input logic [5:0] p, input logic nc);
        dep_valid = 1; dep_mark = 1; dep_tag = tag; dep_port = p; dep_no_credit = nc;
    endtask

    task automatic drain_all();
        for (int i = 0; i < DEPTH + 2; i++) begin
            drain_ready = 1;
            step();
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        movf = 0;
        mnow = START;
        for (int i = 0; i < SLOTS; i++) sv[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur = "R7 reset";
        compare();

        // R1 R4 R6: one packet whose departure time wraps past zero
        cur = "R1";
        arrive(16'h0011, 12'hA01, 12'hB02, 6'd9);
        step();
        for (int i = 0; i < 20; i++) step();
        cur = "R6";
        depart(16'h0011, 6'd5, 1'b1);
        step();
        check("R1 wrapped departure below arrival", drain_data[31:0] < drain_data[63:32],
              128'(drain_data[31:0]), 128'(drain_data[63:32]));
        check("R6 field out-of-credit", drain_data[116] === 1'b1, 128'(drain_data[116]), 128'(1));
        cur = "R4";
        drain_ready = 1;
        step();

        // R2 R5: unmarked traffic and unmatched departures leave nothing
        cur = "R2";
        arr_valid = 1; arr_mark = 0; arr_tag = 16'h0022;
        step();
        cur = "R5";
        depart(16'h0022, 6'd1, 1'b0);
        step();
        arrive(16'h0030, 12'h030, 12'h031, 6'd2);
        step();
        dep_valid = 1; dep_mark = 0; dep_tag = 16'h0030;
        step();
        depart(16'h0099, 6'd3, 1'b0);
        step();
        depart(16'h0030, 6'd4, 1'b0);
        step();
        drain_all();

        // R3: fifth concurrent marked packet is dropped
        cur = "R3";
        for (int i = 1; i <= 5; i++) begin
            arrive(16'(i), 12'(i * 3), 12'(i * 5), 6'(i));
            step();
        end
        depart(16'd5, 6'd7, 1'b0);
        step();
        depart(16'd3, 6'd1, 1'b0); step();
        depart(16'd1, 6'd2, 1'b1); step();
        depart(16'd4, 6'd3, 1'b0); step();
        depart(16'd2, 6'd4, 1'b0); step();
        drain_all();

        // R9: same-cycle arrival is not matched
        cur = "R9";
        arrive(16'h0007, 12'h070, 12'h071, 6'd7);
        depart(16'h0007, 6'd6, 1'b0);
        step();
        step();
        depart(16'h0007, 6'd6, 1'b0);
        step();
        // full table: a freed slot is not reused the same cycle
        for (int i = 0; i < 4; i++) begin
            arrive(16'h0100 + 16'(i), 12'(i), 12'(i), 6'(i));
            step();
        end
        depart(16'h0100, 6'd1, 1'b0);
        arrive(16'h0200, 12'h200, 12'h201, 6'd0);
        step();
        depart(16'h0200, 6'd2, 1'b0); step();
        for (int i = 1; i < 4; i++) begin
            depart(16'h0100 + 16'(i), 6'(i), 1'b0);
            step();
        end
        drain_all();

        // R4: duplicate tags, lowest slot wins
        cur = "R4";
        arrive(16'h0009, 12'h111, 12'h001, 6'd1); step();
        arrive(16'h0009, 12'h222, 12'h002, 6'd2); step();
        depart(16'h0009, 6'd8, 1'b0); step();
        check("R4 lowest slot source", drain_data[103:92] === 12'h111,
              128'(drain_data[103:92]), 128'(12'h111));
        depart(16'h0009, 6'd9, 1'b0); step();
        drain_all();

        // R8: overwrite oldest when full, sticky flag
        cur = "R8";
        for (int i = 0; i < DEPTH + 3; i++) begin
            arrive(16'h0400 + 16'(i), 12'(i), 12'(i + 1), 6'(i));
            step();
            depart(16'h0400 + 16'(i), 6'(i), 1'b0);
            step();
        end
        check("R8 overflow raised", overflow === 1'b1, 128'(overflow), 128'(1));
        // full log: write with simultaneous pop loses nothing
        arrive(16'h0500, 12'h500, 12'h501, 6'd5); step();
        depart(16'h0500, 6'd5, 1'b0);
        drain_ready = 1;
        step();
        // R7: back-to-back pops while records keep arriving
        cur = "R7";
        for (int i = 0; i < 6; i++) begin
            arrive(16'h0600 + 16'(i), 12'(i), 12'(i), 6'(i));
            drain_ready = 1;
            step();
            depart(16'h0600 + 16'(i), 6'(i), 1'(i & 1));
            drain_ready = 1;
            step();
        end
        drain_all();
        check("R8 overflow still set after drain", overflow === 1'b1, 128'(overflow), 128'(1));

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule